// File: doc/BRIEF.md
# Multi-Stream Line Prefetch Engine

The block keeps up to four independent prefetch streams and turns each into a series of cache-line fetch requests on one request port. Software or a dispatch stage starts a stream with a touch command. The command names the stream slot and gives a start byte address, a block length in 16-byte vectors, a number of blocks, a signed byte stride between block starts, and a transient placement hint. The engine walks the stream line by line and block by block. It sends every line address to a memory or cache port that uses a valid/ready handshake. Each request carries the stream's transient hint so the cache can pick a placement.

The engine issues at most one request per cycle. Active slots take turns in round-robin order. A stop command names one slot and cancels it at once, which drops a stream that was started speculatively. A touch to a slot that is already busy throws away that slot's old descriptor and starts the new one from its first line. Each slot drives a busy flag. The cache, address translation and any response path sit outside this block.

Top module: `pf_stream_engine`

## Requirements
- R1: After synchronous reset, `stream_busy` is 0 and `req_valid` is 0.
- R2: A stream with start address X, stride S, L = ceil(size/2) lines per block and C blocks issues these line addresses in order: ((X + b·S) mod 2^32) >> 5, plus k, for b from 0 to C−1 in the outer loop and k from 0 to L−1 in the inner loop. `req_line` is bits [31:5] of the byte address, and the line arithmetic wraps modulo 2^27.
- R3: Field encodings: `touch_size` is an unsigned count of 16-byte vectors from 0 to 32. `touch_count` is an unsigned block count from 0 to 256. `touch_stride` is a 17-bit two's-complement byte stride. Line size is 32 bytes.
- R4: `stream_busy[i]` rises in the cycle after a touch to slot i is accepted. It falls in the cycle after the handshake of that stream's last request.
- R5: When several slots are active, one request is granted per cycle in rotating order, starting after the slot granted last. After reset, slot 0 has first turn.
- R6: A stop command for slot i clears `stream_busy[i]` in the next cycle, and that slot issues no further requests. The other slots are unaffected.
- R7: While `req_valid` is high and `req_ready` is low, and no touch or stop arrives, `req_line` and `req_transient` hold steady in the next cycle.
- R8: A touch with size 0 or count 0 issues no request and leaves the slot idle.
- R9: A touch to a busy slot replaces its descriptor. The next request from that slot is the first line of the new stream.
- R10: `req_transient` equals the transient hint of the touch that started the stream the request belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| touch_valid | input | 1 | Touch command strobe |
| touch_id | input | 2 | Slot addressed by the touch |
| touch_addr | input | 32 | Byte address of the first block |
| touch_size | input | 6 | Block length in 16-byte vectors (0..32) |
| touch_count | input | 9 | Number of blocks (0..256) |
| touch_stride | input | 17 | Signed byte distance between block starts |
| touch_transient | input | 1 | Placement hint for the stream |
| stop_valid | input | 1 | Stop command strobe (wins over a touch to the same slot) |
| stop_id | input | 2 | Slot to cancel |
| req_valid | output | 1 | A line request is offered |
| req_ready | input | 1 | Port accepts the offered request |
| req_line | output | 27 | Line address (byte address bits 31..5) |
| req_transient | output | 1 | Placement hint of the offered request |
| stream_busy | output | 4 | Per-slot active flags |

## Verification
A touch is registered on one edge. The first line of the stream, and the busy flag, appear right after that edge, so the bench samples them at the next falling edge. Each accepted request moves the stream on at that same rising edge. For this reason every following expected line is compared one falling edge later, and the falling busy flag is checked one falling edge after the last handshake. Stop and replacement touches act on the next edge, so their effect is read at the falling edge right after it. Stall checks repeat the comparison at each falling edge while ready stays low.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int ADDR_W      = 32;
    localparam int LINE_OFF    = 5;
    localparam int LINE_W      = ADDR_W - LINE_OFF;
    localparam int SIZE_W      = 6;
    localparam int COUNT_W     = 9;
    localparam int STRIDE_W    = 17;
    localparam int NUM_STREAMS = 4;

    typedef struct packed {
        logic [ADDR_W-1:0]   addr;
        logic [SIZE_W-1:0]   size;
        logic [COUNT_W-1:0]  count;
        logic [STRIDE_W-1:0] stride;
        logic                transient;
    } touch_desc_t;

    // two 16-byte vectors fit in one line; round the vector count up
    function automatic logic [SIZE_W-1:0] lines_per_block(input logic [SIZE_W-1:0] size);
        return (size + SIZE_W'(1)) >> 1;
    endfunction

    function automatic logic [ADDR_W-1:0] widen_stride(input logic [STRIDE_W-1:0] s);
        return {{(ADDR_W-STRIDE_W){s[STRIDE_W-1]}}, s};
    endfunction
endpackage

// File: rtl/pf_stream_slot.sv
module pf_stream_slot
    import pf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  touch_desc_t       desc,
    input  logic              stop,
    input  logic              advance,
    output logic              active,
    output logic [LINE_W-1:0] line_addr,
    output logic              transient
);
    logic [ADDR_W-1:0]   blk_addr;
    logic [ADDR_W-1:0]   stride_q;
    logic [COUNT_W-1:0]  blocks_left;
    logic [SIZE_W-1:0]   lines;
    logic [SIZE_W-1:0]   line_idx;
    logic                last_line;

    assign last_line = (line_idx == lines - SIZE_W'(1));
    assign line_addr = LINE_W'(blk_addr >> LINE_OFF) + LINE_W'(line_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            active      <= 1'b0;
            blk_addr    <= '0;
            stride_q    <= '0;
            blocks_left <= '0;
            lines       <= '0;
            line_idx    <= '0;
            transient   <= 1'b0;
        end else if (stop) begin
            active <= 1'b0;
        end else if (load) begin
            active      <= (desc.size != '0) && (desc.count != '0);
            blk_addr    <= desc.addr;
            stride_q    <= widen_stride(desc.stride);
            blocks_left <= desc.count;
            lines       <= lines_per_block(desc.size);
            line_idx    <= '0;
            transient   <= desc.transient;
        end else if (advance && active) begin
            if (last_line) begin
                line_idx    <= '0;
                blk_addr    <= blk_addr + stride_q;
                blocks_left <= blocks_left - COUNT_W'(1);
                if (blocks_left == COUNT_W'(1))
                    active <= 1'b0;
            end else begin
                line_idx <= line_idx + SIZE_W'(1);
            end
        end
    end

    // R8: an empty descriptor never makes the slot active
    a_r8_empty_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (load && !stop && (desc.size == '0 || desc.count == '0)) |=> !active);

    // R6: stop always clears the slot
    a_r6_stop_clears: assert property (@(posedge clk) disable iff (rst)
        stop |=> !active);

    // R4: without a grant the position within the stream holds
    a_r4_hold_position: assert property (@(posedge clk) disable iff (rst)
        (active && !advance && !load && !stop) |=>
            (active && $stable(blocks_left) && $stable(line_idx)));
endmodule

// File: rtl/pf_rr_arbiter.sv
module pf_rr_arbiter #(
    parameter int N = pf_pkg::NUM_STREAMS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         accept,
    output logic [N-1:0] grant
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    logic [PTR_W-1:0] last_q;

    always_comb begin
        grant = '0;
        for (int off = 1; off <= N; off++) begin
            int idx;
            idx = (int'(last_q) + off) % N;
            if (req[idx] && grant == '0)
                grant[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= PTR_W'(N - 1);
        end else if (accept) begin
            for (int j = 0; j < N; j++)
                if (grant[j]) last_q <= PTR_W'(j);
        end
    end

    a_r5_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    a_r5_grant_only_requester: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);
    a_r5_no_idle_with_work: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> (grant != '0));
endmodule

// File: rtl/pf_stream_engine.sv
module pf_stream_engine
    import pf_pkg::*;
#(
    parameter int N    = NUM_STREAMS,
    parameter int ID_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                touch_valid,
    input  logic [ID_W-1:0]     touch_id,
    input  logic [ADDR_W-1:0]   touch_addr,
    input  logic [SIZE_W-1:0]   touch_size,
    input  logic [COUNT_W-1:0]  touch_count,
    input  logic [STRIDE_W-1:0] touch_stride,
    input  logic                touch_transient,
    input  logic                stop_valid,
    input  logic [ID_W-1:0]     stop_id,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [LINE_W-1:0]   req_line,
    output logic                req_transient,
    output logic [N-1:0]        stream_busy
);
    touch_desc_t       in_desc;
    logic [N-1:0]      load, stop_hit, grant, advance, slot_tr;
    logic [LINE_W-1:0] slot_line [N];

    assign in_desc = '{addr: touch_addr, size: touch_size, count: touch_count,
                       stride: touch_stride, transient: touch_transient};

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign load[i]     = touch_valid && (touch_id == ID_W'(i));
        assign stop_hit[i] = stop_valid && (stop_id == ID_W'(i));
        assign advance[i]  = grant[i] && req_ready;

        pf_stream_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .load      (load[i]),
            .desc      (in_desc),
            .stop      (stop_hit[i]),
            .advance   (advance[i]),
            .active    (stream_busy[i]),
            .line_addr (slot_line[i]),
            .transient (slot_tr[i])
        );
    end

    pf_rr_arbiter #(.N(N)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .req    (stream_busy),
        .accept (req_ready),
        .grant  (grant)
    );

    always_comb begin
        req_line      = '0;
        req_transient = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                req_line      = req_line | slot_line[i];
                req_transient = req_transient | slot_tr[i];
            end
        end
        req_valid = |grant;
    end

    // R7: an offered request is held while the port stalls
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !touch_valid && !stop_valid) |=>
            (req_valid && $stable(req_line) && $stable(req_transient)));

    // R1: nothing is offered while every slot is idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (stream_busy == '0) |-> !req_valid);
endmodule

// File: tb/sim_pf_stream_engine.sv
`timescale 1ns/1ps
module sim_pf_stream_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        touch_valid = 1'b0;
    logic [1:0]  touch_id = '0;
    logic [31:0] touch_addr = '0;
    logic [5:0]  touch_size = '0;
    logic [8:0]  touch_count = '0;
    logic [16:0] touch_stride = '0;
    logic        touch_transient = 1'b0;
    logic        stop_valid = 1'b0;
    logic [1:0]  stop_id = '0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [26:0] req_line;
    logic        req_transient;
    logic [3:0]  stream_busy;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pf_stream_engine u0 (
        .clk(clk), .rst(rst),
        .touch_valid(touch_valid), .touch_id(touch_id), .touch_addr(touch_addr),
        .touch_size(touch_size), .touch_count(touch_count), .touch_stride(touch_stride),
        .touch_transient(touch_transient),
        .stop_valid(stop_valid), .stop_id(stop_id),
        .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
        .req_transient(req_transient), .stream_busy(stream_busy)
    );

    localparam int NV = 6;
    localparam int          V_ID    [NV] = '{0, 1, 2, 3, 0, 1};
    localparam logic [31:0] V_ADDR  [NV] = '{32'h0000_1000, 32'h0000_2010, 32'h0000_0400,
                                             32'hFFFF_FFE0, 32'h0000_8000, 32'h0000_0100};
    localparam int          V_SIZE  [NV] = '{4, 3, 32, 1, 1, 2};
    localparam int          V_COUNT [NV] = '{3, 2, 2, 3, 256, 1};
    localparam int          V_STR   [NV] = '{64, -4096, 32768, 32, -32768, 0};
    localparam bit          V_TR    [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

    function automatic logic [26:0] exp_line(logic [31:0] a, int s, int b, int k);
        logic [31:0] ba;
        ba = a + 32'(b * s);
        return ba[31:5] + 27'(k);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_touch(int id, logic [31:0] a, int sz, int cnt, int st, bit tr);
        touch_valid     = 1'b1;
        touch_id        = 2'(id);
        touch_addr      = a;
        touch_size      = 6'(sz);
        touch_count     = 9'(cnt);
        touch_stride    = 17'(st);
        touch_transient = tr;
        @(negedge clk);
        touch_valid = 1'b0;
    endtask

    task automatic do_stop(int id);
        stop_valid = 1'b1;
        stop_id    = 2'(id);
        @(negedge clk);
        stop_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_req(logic [26:0] line, bit tr, string req);
        check(req_valid === 1'b1, req, 32'(req_valid), 32'd1);
        check(req_line === line, req, 32'(req_line), 32'(line));
        check(req_transient === tr, {req, "/R10"}, 32'(req_transient), 32'(tr));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check(stream_busy === 4'b0000, "R1", 32'(stream_busy), 32'd0);
        check(req_valid === 1'b0, "R1", 32'(req_valid), 32'd0);

        // R2 R3 R4 R10: table of single-stream walks, port always ready
        req_ready = 1'b1;
        for (int v = 0; v < NV; v++) begin
            int lines;
            lines = (V_SIZE[v] + 1) / 2;
            do_touch(V_ID[v], V_ADDR[v], V_SIZE[v], V_COUNT[v], V_STR[v], V_TR[v]);
            check(stream_busy[V_ID[v]] === 1'b1, "R4", 32'(stream_busy), 32'(1 << V_ID[v]));
            for (int b = 0; b < V_COUNT[v]; b++) begin
                for (int k = 0; k < lines; k++) begin
                    expect_req(exp_line(V_ADDR[v], V_STR[v], b, k), V_TR[v], "R2");
                    @(negedge clk);
                end
            end
            check(stream_busy === 4'b0000, "R4", 32'(stream_busy), 32'd0);
            check(req_valid === 1'b0, "R4", 32'(req_valid), 32'd0);
        end

        // R8: empty descriptors
        do_touch(2, 32'h100, 0, 5, 32, 1'b0);
        check(stream_busy === 4'b0000, "R8", 32'(stream_busy), 32'd0);
        check(req_valid === 1'b0, "R8", 32'(req_valid), 32'd0);
        do_touch(3, 32'h100, 4, 0, 32, 1'b0);
        check(stream_busy === 4'b0000, "R8", 32'(stream_busy), 32'd0);
        check(req_valid === 1'b0, "R8", 32'(req_valid), 32'd0);

        // R5 R7: two streams after reset, stalled then drained
        do_reset();
        do_touch(0, 32'h0000_1000, 4, 1, 0, 1'b0);
        do_touch(1, 32'h0000_4000, 4, 1, 0, 1'b1);
        check(stream_busy === 4'b0011, "R4", 32'(stream_busy), 32'h3);
        for (int c = 0; c < 3; c++) begin
            expect_req(27'h80, 1'b0, "R7");
            @(negedge clk);
        end
        req_ready = 1'b1;
        expect_req(27'h080, 1'b0, "R5");
        @(negedge clk);
        expect_req(27'h200, 1'b1, "R5");
        @(negedge clk);
        expect_req(27'h081, 1'b0, "R5");
        @(negedge clk);
        expect_req(27'h201, 1'b1, "R5");
        @(negedge clk);
        check(stream_busy === 4'b0000, "R5", 32'(stream_busy), 32'd0);

        // R6: stop one of two streams
        req_ready = 1'b0;
        do_touch(2, 32'h0000_0000, 2, 10, 32, 1'b0);
        do_touch(3, 32'h0000_0100, 2, 1, 0, 1'b1);
        check(stream_busy === 4'b1100, "R6", 32'(stream_busy), 32'hC);
        do_stop(2);
        check(stream_busy === 4'b1000, "R6", 32'(stream_busy), 32'h8);
        expect_req(27'h8, 1'b1, "R6");
        req_ready = 1'b1;
        @(negedge clk);
        check(stream_busy === 4'b0000, "R6", 32'(stream_busy), 32'd0);
        check(req_valid === 1'b0, "R6", 32'(req_valid), 32'd0);

        // R9: replace a running stream
        req_ready = 1'b0;
        do_touch(1, 32'h0000_1000, 2, 4, 32, 1'b0);
        req_ready = 1'b1;
        expect_req(27'h80, 1'b0, "R9");
        @(negedge clk);
        req_ready = 1'b0;
        expect_req(27'h81, 1'b0, "R9");
        do_touch(1, 32'h0000_3000, 2, 2, 32, 1'b1);
        expect_req(27'h180, 1'b1, "R9");
        req_ready = 1'b1;
        @(negedge clk);
        expect_req(27'h181, 1'b1, "R9");
        @(negedge clk);
        check(stream_busy === 4'b0000, "R9", 32'(stream_busy), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule